// File: doc/BRIEF.md
# ATA Task-File Disk Controller

This block sits behind a nine-byte I/O window and presents the host with an ATA-style register set: a data port, an error register, five address and count registers, and a status register that also accepts commands, plus an alternate status byte that can be read with no side effect. A 512-byte sector buffer sits between the host and a block storage back end. The host moves data through it one byte at a time over the data port. The storage side fills or drains the buffer while the controller holds a request.

Five commands are decoded: identify, read sectors, write sectors, and verify (two opcodes). A transfer may run to 256 sectors. It starts at an address given either as a linear 28-bit block number or as cylinder/head/sector. The cylinder/head/sector form is converted with a fixed geometry of 16 heads and 63 sectors per track. The block address advances by one after every sector. Each storage request is held until the back end pulses done. If the request is still high in the cycle after done, it is a new request for the next block.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status (offset 7) reads 0x50, the error register (offset 1) reads 0x00 and `blk_req` is low. Status bits: 7 busy, 6 ready, 4 seek-complete, 3 data-request, 0 error.
- R2: Offsets 2 (count), 3 (sector / block bits 7:0), 4 (cylinder low / bits 15:8), 5 (cylinder high / bits 23:16) and 6 (drive-head: bit 6 selects linear mode, bits 3:0 are the head or block bits 27:24) read back what was written while idle. Offset 8 returns the same value as offset 7.
- R3: With drive-head bit 6 clear, the start block is (cylinder*16 + head)*63 + (sector-1). With bit 6 set, it is {dh[3:0], off5, off4, off3}.
- R4: Command 0x20 sets status to 0x80 and raises `blk_req` with `blk_we` low. After `blk_done`, status is 0x58 and 512 data-port reads return the buffer bytes in address order, starting at byte 0.
- R5: A count of N transfers N sectors (0 means 256) at consecutive block numbers. After the last byte of the last sector, status is 0x50.
- R6: Command 0x30 sets status to 0x58 at once. After 512 data-port writes, it issues a request with `blk_we` high, during which `st_rdata` returns the written bytes. It then continues to the next sector or finishes with 0x50.
- R7: Commands 0x40 and 0x41 fetch every sector of the range without ever setting data-request, and finish with 0x50.
- R8: Command 0xEC sets 0x58 at once and yields 512 bytes of little-endian words: word0=0x0040, word1=cylinder count, word3=16, word6=63, word49=0x0200, words 60/61 = total sectors (low/high), all other words 0. Afterwards status is 0x50.
- R9: Any other opcode gives status 0x51 and error 0x04 without a storage request. The next accepted known command clears the error to 0x00.
- R10: Data-port accesses while data-request is clear are ignored. Register and command writes while a command is in progress are ignored.
- R11: Busy and data-request are never set together. Once raised, `blk_req` and `blk_lba` hold steady until `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_ofs | input | 4 | Register offset within the window (0..8) |
| io_rd | input | 1 | Host read strobe, one cycle per byte |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational on io_ofs) |
| blk_req | output | 1 | Storage request, held until blk_done |
| blk_we | output | 1 | 1: request writes the buffer to storage; 0: fills it |
| blk_lba | output | 28 | Block number of the current request |
| blk_done | input | 1 | One-cycle completion pulse from storage |
| st_addr | input | 9 | Storage-side buffer byte address |
| st_we | input | 1 | Storage-side buffer write (honoured only during a fill) |
| st_wdata | input | 8 | Storage-side buffer write data |
| st_rdata | output | 8 | Storage-side buffer read data |

## Verification
Assertions cover the rules that hold on every cycle: busy and data-request never overlap, a pending storage request keeps its level and block number, an active command always has sectors left, an error never coexists with busy or data-request, and the buffer never has two writers at once. Only the bench scenarios can show the data path itself. These cover the cylinder/head/sector arithmetic across all heads, the byte order through the buffer in both directions, the identify word contents, and the increment of the block number across multi-sector and 256-sector runs. They also show that accesses arriving in the wrong phase are ignored.

// File: rtl/ata_pkg.sv
// Shared constants, types and the geometry translation for the ATA task-file controller.
// Assumes a fixed geometry of 16 heads and 63 sectors per track.
package ata_pkg;

    localparam int HEADS = 16;
    localparam int SPT   = 63;

    // Register offsets inside the I/O window
    localparam logic [3:0] OFS_DATA  = 4'd0;
    localparam logic [3:0] OFS_ERR   = 4'd1;
    localparam logic [3:0] OFS_CNT   = 4'd2;
    localparam logic [3:0] OFS_SECT  = 4'd3;
    localparam logic [3:0] OFS_CYLL  = 4'd4;
    localparam logic [3:0] OFS_CYLH  = 4'd5;
    localparam logic [3:0] OFS_DH    = 4'd6;
    localparam logic [3:0] OFS_CMD   = 4'd7;
    localparam logic [3:0] OFS_ALT   = 4'd8;

    // Command opcodes
    localparam logic [7:0] OPC_READ   = 8'h20;
    localparam logic [7:0] OPC_WRITE  = 8'h30;
    localparam logic [7:0] OPC_VFY_A  = 8'h40;
    localparam logic [7:0] OPC_VFY_B  = 8'h41;
    localparam logic [7:0] OPC_IDENT  = 8'hEC;

    localparam logic [7:0] ERR_ABORT  = 8'h04;

    typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_HOST, PH_FLUSH} ata_phase_e;
    typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_VERIFY, OP_IDENT} ata_op_e;

    // Cylinder/head/sector to linear block number
    function automatic logic [27:0] chs_to_lba(input logic [15:0] cyl,
                                               input logic [3:0]  head,
                                               input logic [7:0]  sect);
        logic [27:0] track;
        track = {12'd0, cyl} * 28'(HEADS) + {24'd0, head};
        return track * 28'(SPT) + {20'd0, sect} - 28'd1;
    endfunction

endpackage

// File: rtl/ata_sector_buf.sv
// One-sector byte buffer with a host port and a storage port.
// Assumes the two ports never write in the same cycle (phases are exclusive);
// reads are combinational on both ports.
module ata_sector_buf #(
    parameter int BYTES = 512,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic [AW-1:0] s_addr,
    input  logic          s_we,
    input  logic [7:0]    s_wdata,
    output logic [7:0]    s_rdata
);
    logic [7:0] mem [BYTES];

    // Storage array write, host port first
    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_addr] <= h_wdata;
        else if (s_we)
            mem[s_addr] <= s_wdata;
    end

    assign h_rdata = mem[h_addr];
    assign s_rdata = mem[s_addr];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n) !(h_we && s_we)); // R11

endmodule

// File: rtl/ata_ident_gen.sv
// Generates the identify block byte by byte from the configured geometry.
// Assumes little-endian words: byte 2w is the low half of word w.
module ata_ident_gen #(
    parameter int CYLS  = 1024,
    parameter int BYTES = 512,
    localparam int AW   = $clog2(BYTES),
    localparam logic [27:0] TOTAL = 28'(CYLS * ata_pkg::HEADS * ata_pkg::SPT)
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    byte_o
);
    logic [15:0] word;

    // Word contents selected by word index
    always_comb begin
        unique case (idx[AW-1:1])
            (AW-1)'(0):  word = 16'h0040;
            (AW-1)'(1):  word = 16'(CYLS);
            (AW-1)'(3):  word = 16'(ata_pkg::HEADS);
            (AW-1)'(6):  word = 16'(ata_pkg::SPT);
            (AW-1)'(49): word = 16'h0200;
            (AW-1)'(60): word = TOTAL[15:0];
            (AW-1)'(61): word = {4'd0, TOTAL[27:16]};
            default:     word = 16'h0000;
        endcase
    end

    assign byte_o = idx[0] ? word[15:8] : word[7:0];

endmodule

// File: rtl/ata_taskfile_regs.sv
// Holds the count, address and drive-head registers and forms the start block.
// Assumes the caller gates wr_en so that writes land only while idle.
module ata_taskfile_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  ofs,
    input  logic [7:0]  wdata,
    output logic [7:0]  cnt,
    output logic [7:0]  sect,
    output logic [7:0]  cyl_lo,
    output logic [7:0]  cyl_hi,
    output logic [7:0]  dev_head,
    output logic [27:0] start_lba
);
    import ata_pkg::*;

    // Register file update from host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= 8'd1;
            sect     <= 8'd1;
            cyl_lo   <= 8'd0;
            cyl_hi   <= 8'd0;
            dev_head <= 8'hA0;
        end else if (wr_en) begin
            unique case (ofs)
                OFS_CNT:  cnt      <= wdata;
                OFS_SECT: sect     <= wdata;
                OFS_CYLL: cyl_lo   <= wdata;
                OFS_CYLH: cyl_hi   <= wdata;
                OFS_DH:   dev_head <= wdata;
                default:  ;
            endcase
        end
    end

    // Start block: linear when drive-head bit 6 is set, otherwise geometry translation
    always_comb begin
        if (dev_head[6])
            start_lba = {dev_head[3:0], cyl_hi, cyl_lo, sect};
        else
            start_lba = chs_to_lba({cyl_hi, cyl_lo}, dev_head[3:0], sect);
    end

endmodule

// File: rtl/ata_xfer_ctrl.sv
// Command sequencer: accepts opcodes, walks sectors, drives the storage
// request and the host byte pointer. Assumes one host access per strobe cycle.
module ata_xfer_ctrl #(
    parameter int BYTES = 512,
    localparam int AW   = $clog2(BYTES),
    localparam logic [AW-1:0] LAST = AW'(BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [27:0]       start_lba,
    input  logic [7:0]        cnt,
    input  logic              blk_done,
    output ata_pkg::ata_phase_e phase,
    output ata_pkg::ata_op_e  op,
    output logic [AW-1:0]     ptr,
    output logic              host_we,
    output logic              blk_req,
    output logic              blk_we,
    output logic [27:0]       blk_lba,
    output logic              bsy,
    output logic              drq,
    output logic              err
);
    import ata_pkg::*;

    logic [8:0]  rem;
    logic [27:0] lba;
    logic        acc;
    logic        last_sec;
    logic        known;

    assign known    = (cmd == OPC_READ) || (cmd == OPC_WRITE) || (cmd == OPC_VFY_A) ||
                      (cmd == OPC_VFY_B) || (cmd == OPC_IDENT);
    assign acc      = (phase == PH_HOST) && ((op == OP_WRITE) ? data_wr : data_rd);
    assign last_sec = (rem == 9'd1);

    // Phase, pointer, block number and remaining-sector sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            op    <= OP_READ;
            ptr   <= '0;
            lba   <= '0;
            rem   <= '0;
            err   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (cmd_wr) begin
                    lba <= start_lba;
                    rem <= (cnt == 8'd0) ? 9'd256 : {1'b0, cnt};
                    ptr <= '0;
                    err <= !known;
                    unique case (cmd)
                        OPC_READ:  begin op <= OP_READ;   phase <= PH_FETCH; end
                        OPC_WRITE: begin op <= OP_WRITE;  phase <= PH_HOST;  end
                        OPC_VFY_A,
                        OPC_VFY_B: begin op <= OP_VERIFY; phase <= PH_FETCH; end
                        OPC_IDENT: begin op <= OP_IDENT;  phase <= PH_HOST; rem <= 9'd1; end
                        default:   phase <= PH_IDLE;
                    endcase
                end
                PH_FETCH: if (blk_done) begin
                    if (op == OP_VERIFY) begin
                        lba   <= lba + 28'd1;
                        rem   <= rem - 9'd1;
                        phase <= last_sec ? PH_IDLE : PH_FETCH;
                    end else begin
                        ptr   <= '0;
                        phase <= PH_HOST;
                    end
                end
                PH_HOST: if (acc) begin
                    if (ptr == LAST) begin
                        ptr <= '0;
                        if (op == OP_WRITE)
                            phase <= PH_FLUSH;
                        else if (op == OP_IDENT)
                            phase <= PH_IDLE;
                        else begin
                            lba   <= lba + 28'd1;
                            rem   <= rem - 9'd1;
                            phase <= last_sec ? PH_IDLE : PH_FETCH;
                        end
                    end else begin
                        ptr <= ptr + AW'(1);
                    end
                end
                PH_FLUSH: if (blk_done) begin
                    lba   <= lba + 28'd1;
                    rem   <= rem - 9'd1;
                    phase <= last_sec ? PH_IDLE : PH_HOST;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign host_we = acc && (op == OP_WRITE);
    assign blk_req = (phase == PH_FETCH) || (phase == PH_FLUSH);
    assign blk_we  = (phase == PH_FLUSH);
    assign blk_lba = lba;
    assign bsy     = blk_req;
    assign drq     = (phase == PH_HOST);

    AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bsy && drq)); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (blk_req && !blk_done) |=> blk_req); // R11
    AST_LBA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (blk_req && !blk_done) |=> $stable(blk_lba)); // R11
    AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (phase != PH_IDLE) |-> (rem != 9'd0)); // R5
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!bsy && !drq)); // R9
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_IDLE && cmd_wr && known) |=> !err); // R9
    AST_VFY_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_VERIFY) |-> !drq); // R7

endmodule

// File: rtl/ata_taskfile_ctrl.sv
// Top of the ATA task-file controller: nine-byte register window, sector buffer,
// identify generator and sequencer. Assumes one access strobe at a time on the
// host side and storage activity only while blk_req is high.
module ata_taskfile_ctrl #(
    parameter int SECT_BYTES = 512,
    parameter int CYLS       = 1024,
    localparam int PTR_W     = $clog2(SECT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       io_ofs,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             blk_req,
    output logic             blk_we,
    output logic [27:0]      blk_lba,
    input  logic             blk_done,
    input  logic [PTR_W-1:0] st_addr,
    input  logic             st_we,
    input  logic [7:0]       st_wdata,
    output logic [7:0]       st_rdata
);
    import ata_pkg::*;

    logic [7:0]  cnt, sect, cyl_lo, cyl_hi, dev_head;
    logic [27:0] start_lba;
    ata_phase_e  phase;
    ata_op_e     op;
    logic [PTR_W-1:0] ptr;
    logic        host_we, bsy, drq, err;
    logic [7:0]  buf_byte, id_byte, status;
    logic        idle, tf_wr, cmd_wr, data_rd, data_wr;

    assign idle    = (phase == PH_IDLE);
    assign tf_wr   = io_wr && idle && (io_ofs >= OFS_CNT) && (io_ofs <= OFS_DH);
    assign cmd_wr  = io_wr && (io_ofs == OFS_CMD);
    assign data_rd = io_rd && (io_ofs == OFS_DATA);
    assign data_wr = io_wr && (io_ofs == OFS_DATA);

    ata_taskfile_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(tf_wr), .ofs(io_ofs), .wdata(io_wdata),
        .cnt(cnt), .sect(sect), .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .dev_head(dev_head),
        .start_lba(start_lba)
    );

    ata_xfer_ctrl #(.BYTES(SECT_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(io_wdata),
        .data_rd(data_rd), .data_wr(data_wr), .start_lba(start_lba), .cnt(cnt),
        .blk_done(blk_done), .phase(phase), .op(op), .ptr(ptr), .host_we(host_we),
        .blk_req(blk_req), .blk_we(blk_we), .blk_lba(blk_lba),
        .bsy(bsy), .drq(drq), .err(err)
    );

    ata_sector_buf #(.BYTES(SECT_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .h_addr(ptr), .h_we(host_we), .h_wdata(io_wdata), .h_rdata(buf_byte),
        .s_addr(st_addr), .s_we(st_we && (phase == PH_FETCH)), .s_wdata(st_wdata),
        .s_rdata(st_rdata)
    );

    ata_ident_gen #(.CYLS(CYLS), .BYTES(SECT_BYTES)) u_ident (
        .idx(ptr), .byte_o(id_byte)
    );

    assign status = {bsy, !bsy, 1'b0, !bsy, drq, 2'b00, err};

    // Host read data selection by offset
    always_comb begin
        unique case (io_ofs)
            OFS_DATA:         io_rdata = (op == OP_IDENT) ? id_byte : buf_byte;
            OFS_ERR:          io_rdata = err ? ERR_ABORT : 8'h00;
            OFS_CNT:          io_rdata = cnt;
            OFS_SECT:         io_rdata = sect;
            OFS_CYLL:         io_rdata = cyl_lo;
            OFS_CYLH:         io_rdata = cyl_hi;
            OFS_DH:           io_rdata = dev_head;
            OFS_CMD, OFS_ALT: io_rdata = status;
            default:          io_rdata = 8'hFF;
        endcase
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (status[7:6] == 2'b01) |-> !blk_req); // R11
    AST_TF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!idle) |=> $stable(cnt)); // R10

endmodule

// File: tb/ata_taskfile_ctrl_tb.sv
// Self-checking bench: host register tasks plus a behavioural storage responder.
module ata_taskfile_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n;
    logic [3:0] io_ofs;
    logic io_rd, io_wr;
    logic [7:0] io_wdata, io_rdata;
    logic blk_req, blk_we, blk_done;
    logic [27:0] blk_lba;
    logic [8:0] st_addr;
    logic st_we;
    logic [7:0] st_wdata, st_rdata;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int wr_mism = 0;
    int wr_reqs = 0;
    bit fast_fill = 0;
    logic [27:0] lba_log [512];

    always #2.5 clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_ofs(io_ofs), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .blk_req(blk_req), .blk_we(blk_we),
        .blk_lba(blk_lba), .blk_done(blk_done), .st_addr(st_addr), .st_we(st_we),
        .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    function automatic logic [7:0] rpat(input logic [27:0] lba, input int i);
        return 8'(lba[7:0] * 13 + i + (i >> 8) * 91) ^ lba[15:8];
    endfunction

    function automatic logic [7:0] wpat(input logic [27:0] lba, input int i);
        return 8'(i * 5 + lba[7:0] * 17 + 3);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        io_ofs = o; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] o, output logic [7:0] d);
        @(negedge clk);
        io_ofs = o; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // Poll alternate status until busy clears; reports whether data-request was seen
    task automatic wait_nbsy(output logic [7:0] s, output bit saw_drq);
        saw_drq = 0;
        for (int n = 0; n < 20000; n++) begin
            rd(4'd8, s);
            if (s[3]) saw_drq = 1;
            if (!s[7]) break;
        end
    endtask

    task automatic set_lba(input logic [27:0] l, input logic [7:0] c);
        wr(4'd3, l[7:0]); wr(4'd4, l[15:8]); wr(4'd5, l[23:16]);
        wr(4'd6, {4'hE, l[27:24]}); wr(4'd2, c);
    endtask

    // Storage responder: fills or drains the buffer, then pulses done
    initial begin
        logic [27:0] l;
        logic w;
        blk_done = 0; st_we = 0; st_addr = '0; st_wdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && blk_req === 1'b1) begin
                l = blk_lba; w = blk_we;
                lba_log[req_cnt % 512] = l;
                req_cnt++;
                repeat (2) @(negedge clk);
                if (!w) begin
                    if (!fast_fill) begin
                        for (int i = 0; i < 512; i++) begin
                            st_addr = 9'(i); st_wdata = rpat(l, i); st_we = 1'b1;
                            @(negedge clk);
                        end
                        st_we = 1'b0;
                    end
                end else begin
                    wr_reqs++;
                    for (int i = 0; i < 512; i++) begin
                        st_addr = 9'(i);
                        #1 if (st_rdata !== wpat(l, i)) wr_mism++;
                        @(negedge clk);
                    end
                end
                blk_done = 1'b1;
                @(negedge clk);
                blk_done = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2, s;
        logic [7:0] idb [512];
        bit sd;
        int base, mism, exp, w;
        rst_n = 0; io_ofs = 0; io_rd = 0; io_wr = 0; io_wdata = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(4'd7, v); chk(v == 8'h50, "R1 status", v, 8'h50);
        rd(4'd1, v); chk(v == 8'h00, "R1 error", v, 0);
        chk(blk_req == 1'b0, "R1 blk_req", blk_req, 0);

        // R2 register read-back and alternate status
        for (int k = 2; k <= 6; k++) wr(4'(k), 8'(k * 17 + 1));
        mism = 0;
        for (int k = 2; k <= 6; k++) begin rd(4'(k), v); if (v != 8'(k * 17 + 1)) mism++; end
        chk(mism == 0, "R2 readback", mism, 0);
        rd(4'd8, v); rd(4'd7, v2); chk(v == v2, "R2 alt status", v, v2);

        // R3 geometry translation sweep over all heads, via verify
        for (int h = 0; h < 16; h++) begin
            for (int j = 0; j < 3; j++) begin
                int c, sc;
                c  = (j == 0) ? 0 : (j == 1) ? 5 : 1023;
                sc = (j == 0) ? 1 : (j == 1) ? 63 : 17;
                wr(4'd3, 8'(sc)); wr(4'd4, 8'(c)); wr(4'd5, 8'(c >> 8));
                wr(4'd6, 8'hA0 | 8'(h)); wr(4'd2, 8'd1);
                base = req_cnt;
                wr(4'd7, 8'h40);
                wait_nbsy(s, sd);
                exp = (c * 16 + h) * 63 + sc - 1;
                chk(req_cnt == base + 1 && lba_log[base % 512] == 28'(exp),
                    "R3 chs lba", int'(lba_log[base % 512]), exp);
            end
        end
        base = req_cnt;
        set_lba(28'h9ABCDEF, 8'd1); wr(4'd7, 8'h40); wait_nbsy(s, sd);
        chk(lba_log[base % 512] == 28'h9ABCDEF, "R3 linear lba", int'(lba_log[base % 512]), 28'h9ABCDEF);

        // R10 data-port accesses while idle are ignored
        rd(4'd0, v); rd(4'd0, v); wr(4'd0, 8'h5A);

        // R4 / R5 three-sector read
        set_lba(28'd100, 8'd3);
        base = req_cnt;
        wr(4'd7, 8'h20);
        rd(4'd8, v); chk(v == 8'h80, "R4 busy status", v, 8'h80);
        chk(blk_req && !blk_we, "R4 read request", {blk_req, blk_we}, 2'b10);
        for (int sct = 0; sct < 3; sct++) begin
            wait_nbsy(s, sd);
            chk(s == 8'h58, "R4 data ready", s, 8'h58);
            mism = 0;
            for (int i = 0; i < 512; i++) begin
                rd(4'd0, v);
                if (v != rpat(28'(100 + sct), i)) mism++;
            end
            chk(mism == 0, "R4 sector bytes", mism, 0);
        end
        rd(4'd7, v); chk(v == 8'h50, "R5 read done", v, 8'h50);
        chk(req_cnt == base + 3 && lba_log[(base + 2) % 512] == 28'd102, "R5 lba advance",
            int'(lba_log[(base + 2) % 512]), 102);

        // R6 two-sector write
        set_lba(28'd200, 8'd2);
        wr_mism = 0; wr_reqs = 0;
        wr(4'd7, 8'h30);
        rd(4'd8, v); chk(v == 8'h58, "R6 immediate drq", v, 8'h58);
        for (int sct = 0; sct < 2; sct++) begin
            for (int i = 0; i < 512; i++) wr(4'd0, wpat(28'(200 + sct), i));
            rd(4'd8, v); chk(v == 8'h80, "R6 flush busy", v, 8'h80);
            wait_nbsy(s, sd);
        end
        chk(wr_reqs == 2 && wr_mism == 0, "R6 written bytes", wr_mism, 0);
        rd(4'd7, v); chk(v == 8'h50, "R6 write done", v, 8'h50);

        // R7 verify, both opcodes
        set_lba(28'd300, 8'd4);
        base = req_cnt;
        wr(4'd7, 8'h41); wait_nbsy(s, sd);
        chk(!sd && s == 8'h50, "R7 verify 41 no drq", s, 8'h50);
        chk(req_cnt == base + 4 && lba_log[(base + 3) % 512] == 28'd303, "R7 verify range",
            req_cnt - base, 4);

        // R5 count zero means 256 sectors
        fast_fill = 1;
        set_lba(28'd1000, 8'd0);
        base = req_cnt;
        wr(4'd7, 8'h40); wait_nbsy(s, sd);
        fast_fill = 0;
        chk(req_cnt == base + 256, "R5 count zero", req_cnt - base, 256);
        chk(lba_log[(base + 255) % 512] == 28'd1255, "R5 last lba",
            int'(lba_log[(base + 255) % 512]), 1255);
        chk(!sd && s == 8'h50, "R7 verify 40 no drq", s, 8'h50);

        // R8 identify
        wr(4'd7, 8'hEC);
        rd(4'd8, v); chk(v == 8'h58, "R8 immediate drq", v, 8'h58);
        for (int i = 0; i < 512; i++) rd(4'd0, idb[i]);
        mism = 0;
        for (int k = 0; k < 256; k++) begin
            int e;
            w = {idb[2 * k + 1], idb[2 * k]};
            case (k)
                0: e = 16'h0040; 1: e = 1024; 3: e = 16; 6: e = 63; 49: e = 16'h0200;
                60: e = (1024 * 16 * 63) & 16'hFFFF; 61: e = (1024 * 16 * 63) >> 16;
                default: e = 0;
            endcase
            if (w != e) begin
                mism++;
                chk(0, "R8 identify word", w, e);
            end
        end
        chk(mism == 0, "R8 identify block", mism, 0);
        rd(4'd7, v); chk(v == 8'h50, "R8 done", v, 8'h50);

        // R9 unknown opcode, then clear by a known command
        base = req_cnt;
        wr(4'd7, 8'h91);
        rd(4'd7, v); chk(v == 8'h51, "R9 error status", v, 8'h51);
        rd(4'd1, v); chk(v == 8'h04, "R9 abort bit", v, 8'h04);
        chk(req_cnt == base, "R9 no request", req_cnt - base, 0);
        set_lba(28'd7, 8'd1); wr(4'd7, 8'h40); wait_nbsy(s, sd);
        rd(4'd1, v); chk(v == 8'h00, "R9 error cleared", v, 0);
        rd(4'd7, v); chk(v == 8'h50, "R9 status cleared", v, 8'h50);

        // R10 register and command writes while busy are ignored
        set_lba(28'd400, 8'd1);
        wr(4'd7, 8'h20);
        wr(4'd2, 8'h77); wr(4'd7, 8'hEC);
        wait_nbsy(s, sd);
        mism = 0;
        for (int i = 0; i < 512; i++) begin rd(4'd0, v); if (v != rpat(28'd400, i)) mism++; end
        chk(mism == 0, "R10 command ignored while busy", mism, 0);
        rd(4'd2, v); chk(v == 8'h01, "R10 count unchanged", v, 1);
        rd(4'd7, v); chk(v == 8'h50, "R10 final status", v, 8'h50);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule